// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block steps through a microprogram held in a small register-based control store and turns the current control word into decoded control lines. A microprogram counter addresses the store. The word at that address is read combinationally, so it drives the outputs in the same cycle the counter holds that address. Software or a boot engine fills the store and an opcode-to-start-address mapping table through two synchronous write ports before the sequencer is used.

The next counter value comes from one of five places. An instruction load jumps to the start address that the mapping table gives for the incoming opcode. Otherwise the sequencing field of the current word decides. A plain word moves on to the next address. A branch word tests one selected condition line and either jumps to its target or moves on. An end word returns to the instruction-fetch routine. A wait word holds the counter until the next instruction load.

The control fields are binary coded. Signals that can never be active together share one field, and each field keeps code zero for "no action". Register-output sources, register-input destinations, ALU functions and memory commands each have their own field. Read and write share the memory field, so the two can never be requested in the same cycle.

Top module: `mseq_top`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, upc is 0, which is the start of the fetch routine. Both tables are cleared to zero, so every decoded output is 0.
- R2: A word with sequencing code 0 (bits [1:0], NEXT) sets upc to upc+1 on the next clock edge. The count wraps from 31 to 0.
- R3: When ir_load is high at a clock edge, upc becomes the mapping-table entry for ir_opcode. This takes priority over every sequencing code of the current word.
- R4: A word with sequencing code 1 (BRANCH) tests cond_in[sel], where sel is bits [3:2]. Bit [4] inverts the test. When the result is 1, upc becomes the target held in bits [9:5].
- R5: When a BRANCH test result is 0, upc becomes upc+1.
- R6: A word with sequencing code 2 (END) sets upc to 0 on the next clock edge.
- R7: A word with sequencing code 3 (WAIT) holds upc until ir_load is high.
- R8: The source field, bits [12:10], is decoded as follows. Code 0 raises no line. Code k (1 to 7) raises only src_oh[k-1].
- R9: The ALU field, bits [19:16], is decoded as follows. Code 0 raises no line. Code k (1 to 15) raises only alu_oh[k-1].
- R10: The memory field, bits [21:20], is decoded as follows. Code 1 raises mem_rd only. Code 2 raises mem_wr only. Codes 0 and 3 raise neither. mem_rd and mem_wr are never high together.
- R11: The destination field, bits [15:13], is decoded as follows. Code 0 raises no line. Code k (1 to 7) raises only dst_oh[k-1].
- R12: A write through the control-store port, or through the mapping-table port, takes effect at the clock edge where its enable is high. The sequencer uses the new contents from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_load | input | 1 | A new instruction is loaded; jump to its routine |
| ir_opcode | input | 3 | Opcode of the loaded instruction |
| cond_in | input | 4 | Condition codes and external inputs for branch tests |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 5 | Control-store write address |
| cs_wdata | input | 22 | Control word to write |
| map_we | input | 1 | Mapping-table write enable |
| map_waddr | input | 3 | Opcode whose entry is written |
| map_wdata | input | 5 | Start address to write |
| upc | output | 5 | Current microprogram address |
| src_oh | output | 7 | Decoded register-output source lines |
| dst_oh | output | 7 | Decoded register-input destination lines |
| alu_oh | output | 15 | Decoded ALU function lines |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |

## Verification
Every new upc value is due exactly one rising edge after the stimulus that causes it. That stimulus is either an ir_load pulse or the word at the current address. The decoded lines follow upc in that same cycle, because the store is read without a register. A table write is seen from the cycle after its write edge. The bench drives all inputs on the falling edge, moves one rising edge forward, and samples on the following falling edge. Each check therefore falls one cycle after its cause. Walking whole routines checks the address at every step, so each branch, fall-through, end and hold decision is seen at the exact cycle it is due.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   typedef enum logic [1:0] {
      SQ_NEXT   = 2'd0,
      SQ_BRANCH = 2'd1,
      SQ_END    = 2'd2,
      SQ_WAIT   = 2'd3
   } seq_kind_e;

   localparam logic [1:0] MEMC_NONE  = 2'd0;
   localparam logic [1:0] MEMC_READ  = 2'd1;
   localparam logic [1:0] MEMC_WRITE = 2'd2;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
   parameter int AW  = 5,
   parameter int OPW = 3,
   parameter int CW  = 22
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_we,
   input  logic [AW-1:0]  cs_waddr,
   input  logic [CW-1:0]  cs_wdata,
   input  logic           map_we,
   input  logic [OPW-1:0] map_waddr,
   input  logic [AW-1:0]  map_wdata,
   input  logic [AW-1:0]  rd_addr,
   input  logic [OPW-1:0] opcode,
   output logic [CW-1:0]  word,
   output logic [AW-1:0]  start_addr
);
   localparam int DEPTH = 1 << AW;
   localparam int NOPS  = 1 << OPW;

   logic [CW-1:0] cs_q  [DEPTH];
   logic [AW-1:0] map_q [NOPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cs_q[i] <= '0;
      end else if (cs_we) begin
         cs_q[cs_waddr] <= cs_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NOPS; i++) map_q[i] <= '0;
      end else if (map_we) begin
         map_q[map_waddr] <= map_wdata;
      end
   end

   assign word       = cs_q[rd_addr];
   assign start_addr = map_q[opcode];
endmodule

// File: rtl/mseq_next.sv
module mseq_next
   import mseq_pkg::*;
#(
   parameter int          AW         = 5,
   parameter int unsigned FETCH_BASE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ir_load,
   input  logic [AW-1:0] start_addr,
   input  logic [1:0]    kind,
   input  logic          br_taken,
   input  logic [AW-1:0] br_target,
   output logic [AW-1:0] upc
);
   localparam logic [AW-1:0] FETCH_A = AW'(FETCH_BASE);

   logic [AW-1:0] nxt;
   logic [AW-1:0] inc;

   assign inc = upc + 1'b1;

   always_comb begin
      nxt = inc;
      if (ir_load) begin
         nxt = start_addr;
      end else begin
         case (seq_kind_e'(kind))
            SQ_NEXT:   nxt = inc;
            SQ_BRANCH: nxt = br_taken ? br_target : inc;
            SQ_END:    nxt = FETCH_A;
            SQ_WAIT:   nxt = upc;
            default:   nxt = inc;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= FETCH_A;
      else        upc <= nxt;
   end

   AST_IRLOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |=> upc == $past(start_addr)); // R3
   AST_SEQ_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && kind == SQ_NEXT) |=> upc == AW'($past(upc) + 1'b1)); // R2
   AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && kind == SQ_BRANCH && br_taken) |=> upc == $past(br_target)); // R4
   AST_BR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && kind == SQ_BRANCH && !br_taken) |=> upc == AW'($past(upc) + 1'b1)); // R5
   AST_END_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && kind == SQ_END) |=> upc == FETCH_A); // R6
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ir_load && kind == SQ_WAIT) |=> $stable(upc)); // R7
endmodule

// File: rtl/mseq_onehot.sv
module mseq_onehot #(
   parameter int W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         code,
   output logic [(1<<W)-2:0]    lines
);
   localparam int NL = (1 << W) - 1;

   for (genvar i = 0; i < NL; i++) begin : g_line
      assign lines[i] = (code == W'(i + 1));
   end

   AST_FIELD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lines)); // R8
   AST_FIELD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (code != '0) |-> $countones(lines) == 1); // R9
endmodule

// File: rtl/mseq_top.sv
module mseq_top
   import mseq_pkg::*;
#(
   parameter int          AW         = 5,
   parameter int          OPW        = 3,
   parameter int          NCOND      = 4,
   parameter int          SRCW       = 3,
   parameter int          ALUW       = 4,
   parameter int unsigned FETCH_BASE = 0,
   localparam int CSW    = $clog2(NCOND),
   localparam int KIND_LO = 0,
   localparam int CSEL_LO = KIND_LO + 2,
   localparam int INV_B   = CSEL_LO + CSW,
   localparam int TGT_LO  = INV_B + 1,
   localparam int SRC_LO  = TGT_LO + AW,
   localparam int DST_LO  = SRC_LO + SRCW,
   localparam int ALU_LO  = DST_LO + SRCW,
   localparam int MEM_LO  = ALU_LO + ALUW,
   localparam int CW      = MEM_LO + 2,
   localparam int NSRC    = (1 << SRCW) - 1,
   localparam int NALU    = (1 << ALUW) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_load,
   input  logic [OPW-1:0]   ir_opcode,
   input  logic [NCOND-1:0] cond_in,
   input  logic             cs_we,
   input  logic [AW-1:0]    cs_waddr,
   input  logic [CW-1:0]    cs_wdata,
   input  logic             map_we,
   input  logic [OPW-1:0]   map_waddr,
   input  logic [AW-1:0]    map_wdata,
   output logic [AW-1:0]    upc,
   output logic [NSRC-1:0]  src_oh,
   output logic [NSRC-1:0]  dst_oh,
   output logic [NALU-1:0]  alu_oh,
   output logic             mem_rd,
   output logic             mem_wr
);
   if (NCOND < 2 || (NCOND & (NCOND - 1)) != 0) begin : g_bad_ncond
      $error("NCOND must be a power of two, at least 2");
   end
   if (AW < 2 || AW > 10) begin : g_bad_aw
      $error("AW must lie in 2..10");
   end
   if (FETCH_BASE >= (1 << AW)) begin : g_bad_fetch
      $error("FETCH_BASE outside the control store");
   end
   if (SRCW < 1 || ALUW < 1) begin : g_bad_field
      $error("encoded fields need at least one bit");
   end

   logic [CW-1:0]   word;
   logic [AW-1:0]   start_addr;
   logic [1:0]      kind;
   logic [CSW-1:0]  csel;
   logic            inv;
   logic [AW-1:0]   tgt;
   logic [SRCW-1:0] src_c;
   logic [SRCW-1:0] dst_c;
   logic [ALUW-1:0] alu_c;
   logic [1:0]      mem_c;
   logic            br_taken;

   assign kind  = word[KIND_LO +: 2];
   assign csel  = word[CSEL_LO +: CSW];
   assign inv   = word[INV_B];
   assign tgt   = word[TGT_LO +: AW];
   assign src_c = word[SRC_LO +: SRCW];
   assign dst_c = word[DST_LO +: SRCW];
   assign alu_c = word[ALU_LO +: ALUW];
   assign mem_c = word[MEM_LO +: 2];

   assign br_taken = cond_in[csel] ^ inv;

   mseq_store #(.AW(AW), .OPW(OPW), .CW(CW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
      .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
      .rd_addr(upc), .opcode(ir_opcode),
      .word(word), .start_addr(start_addr)
   );

   mseq_next #(.AW(AW), .FETCH_BASE(FETCH_BASE)) u_next (
      .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .start_addr(start_addr),
      .kind(kind), .br_taken(br_taken), .br_target(tgt), .upc(upc)
   );

   mseq_onehot #(.W(SRCW)) u_src (.clk(clk), .rst_n(rst_n), .code(src_c), .lines(src_oh));
   mseq_onehot #(.W(SRCW)) u_dst (.clk(clk), .rst_n(rst_n), .code(dst_c), .lines(dst_oh));
   mseq_onehot #(.W(ALUW)) u_alu (.clk(clk), .rst_n(rst_n), .code(alu_c), .lines(alu_oh));

   assign mem_rd = (mem_c == MEMC_READ);
   assign mem_wr = (mem_c == MEMC_WRITE);

   AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R10
   AST_IDLE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (word[MEM_LO +: 2] == MEMC_NONE) |-> !mem_rd && !mem_wr); // R10
endmodule

// File: tb/sim_mseq_top.sv
module sim_mseq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir_load = 1'b0;
   logic [2:0]  ir_opcode = '0;
   logic [3:0]  cond_in = '0;
   logic        cs_we = 1'b0;
   logic [4:0]  cs_waddr = '0;
   logic [21:0] cs_wdata = '0;
   logic        map_we = 1'b0;
   logic [2:0]  map_waddr = '0;
   logic [4:0]  map_wdata = '0;
   logic [4:0]  upc;
   logic [6:0]  src_oh, dst_oh;
   logic [14:0] alu_oh;
   logic        mem_rd, mem_wr;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   mseq_top u0 (
      .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_opcode(ir_opcode),
      .cond_in(cond_in), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
      .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
      .upc(upc), .src_oh(src_oh), .dst_oh(dst_oh), .alu_oh(alu_oh),
      .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

   function automatic logic [21:0] mkw(int kind, int csel, int inv, int tgt,
                                        int src, int dst, int alu, int mem);
      logic [21:0] w;
      w = '0;
      w[1:0]   = kind[1:0];
      w[3:2]   = csel[1:0];
      w[4]     = inv[0];
      w[9:5]   = tgt[4:0];
      w[12:10] = src[2:0];
      w[15:13] = dst[2:0];
      w[19:16] = alu[3:0];
      w[21:20] = mem[1:0];
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_cs(input int a, input logic [21:0] d);
      cs_we = 1'b1; cs_waddr = a[4:0]; cs_wdata = d;
      cyc();
      cs_we = 1'b0;
   endtask

   task automatic wr_map(input int op, input int a);
      map_we = 1'b1; map_waddr = op[2:0]; map_wdata = a[4:0];
      cyc();
      map_we = 1'b0;
   endtask

   task automatic dispatch(input int op);
      ir_load = 1'b1; ir_opcode = op[2:0];
      cyc();
      ir_load = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      cyc();
      chk("R1 upc in reset", upc, 0);
      chk("R1 src idle", src_oh, 0);
      chk("R1 alu idle", alu_oh, 0);
      chk("R1 mem idle", {mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      chk("R1 upc after release", upc, 0);
      cyc();
      chk("R2 increment on zero word", upc, 1);
      cyc();
      chk("R2 increment again", upc, 2);
   endtask

   task automatic t_load();
      wr_cs(0,  mkw(0, 0, 0, 0, 1, 0, 0, 1));
      wr_cs(1,  mkw(0, 0, 0, 0, 0, 0, 0, 0));
      wr_cs(2,  mkw(3, 0, 0, 0, 0, 3, 0, 0));
      wr_cs(8,  mkw(0, 0, 0, 0, 2, 4, 5, 0));
      wr_cs(9,  mkw(1, 1, 0, 12, 0, 0, 0, 0));
      wr_cs(10, mkw(0, 0, 0, 0, 0, 0, 15, 3));
      wr_cs(11, mkw(2, 0, 0, 0, 0, 0, 0, 0));
      wr_cs(12, mkw(0, 0, 0, 0, 7, 0, 0, 2));
      wr_cs(13, mkw(2, 0, 0, 0, 0, 0, 0, 0));
      wr_cs(16, mkw(1, 2, 1, 20, 0, 0, 0, 0));
      wr_cs(17, mkw(2, 0, 0, 0, 0, 0, 0, 0));
      wr_cs(20, mkw(2, 0, 0, 0, 0, 0, 1, 0));
      wr_cs(31, mkw(0, 0, 0, 0, 0, 0, 0, 0));
      wr_map(1, 8);
      wr_map(2, 16);
      wr_map(3, 31);
   endtask

   task automatic t_fetch();
      dispatch(0);
      chk("R3 dispatch op0", upc, 0);
      chk("R8 src code1", src_oh, 7'b0000001);
      chk("R10 read", {mem_rd, mem_wr}, 2'b10);
      cyc();
      chk("R2 fetch step", upc, 1);
      chk("R10 none", {mem_rd, mem_wr}, 2'b00);
      cyc();
      chk("R2 to wait word", upc, 2);
      chk("R11 dst code3", dst_oh, 7'b0000100);
      cyc();
      chk("R7 hold 1", upc, 2);
      cyc();
      chk("R7 hold 2", upc, 2);
   endtask

   task automatic t_taken();
      cond_in = 4'b0010;
      dispatch(1);
      chk("R3 dispatch op1", upc, 8);
      chk("R8 src code2", src_oh, 7'b0000010);
      chk("R11 dst code4", dst_oh, 7'b0001000);
      chk("R9 alu code5", alu_oh, 15'h0010);
      cyc();
      chk("R2 to branch", upc, 9);
      cyc();
      chk("R4 branch taken", upc, 12);
      chk("R10 write", {mem_rd, mem_wr}, 2'b01);
      chk("R8 src code7", src_oh, 7'b1000000);
      cyc();
      chk("R2 after target", upc, 13);
      cyc();
      chk("R6 end to fetch", upc, 0);
   endtask

   task automatic t_fall();
      cond_in = 4'b1101;
      dispatch(1);
      cyc();
      cyc();
      chk("R5 fall through", upc, 10);
      chk("R9 alu code15", alu_oh, 15'h4000);
      chk("R10 reserved code", {mem_rd, mem_wr}, 2'b00);
      cyc();
      chk("R2 to end word", upc, 11);
      dispatch(2);
      chk("R3 load beats END", upc, 16);
   endtask

   task automatic t_polarity();
      cond_in = 4'b0000;
      cyc();
      chk("R4 inverted test taken", upc, 20);
      chk("R9 alu code1", alu_oh, 15'h0001);
      cyc();
      chk("R6 end from 20", upc, 0);
      cond_in = 4'b0100;
      dispatch(2);
      cyc();
      chk("R5 inverted test falls", upc, 17);
      cyc();
      chk("R6 end from 17", upc, 0);
   endtask

   task automatic t_wrap();
      dispatch(3);
      chk("R3 dispatch op3", upc, 31);
      cyc();
      chk("R2 wrap to 0", upc, 0);
   endtask

   task automatic t_rewrite();
      wr_cs(20, mkw(2, 0, 0, 0, 0, 0, 2, 0));
      wr_map(3, 20);
      dispatch(3);
      chk("R12 map rewrite", upc, 20);
      chk("R12 word rewrite", alu_oh, 15'h0002);
      cyc();
      chk("R6 end after rewrite", upc, 0);
   endtask

   initial begin
      t_reset();
      t_load();
      t_fetch();
      t_taken();
      t_fall();
      t_polarity();
      t_wrap();
      t_rewrite();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule